// File: doc/BRIEF.md
# Tag Bank Scrub and Reissue Controller

This block owns one ECC-protected tag bank and serves lookups into it. Every stored entry is 40 bits wide: a 7-bit SECDED code in bits [39:33], a 31-bit tag in bits [32:2] and a 2-bit line state in bits [1:0]. The code covers the tag and the state together. A fill port writes new entries; the bank computes their code on the way in, and an injection mask can corrupt chosen bits of the stored word.

A lookup is checked on every read. If the entry is clean, the result comes back at once. If one bit is wrong, the block does not correct in flight. It drops the request from the pipeline (flush strobe) and reads the entry again. It then writes back the corrected tag and state with a freshly computed code, and replays the request from the start (reissue strobe). A replayed lookup that still finds an error is flagged as a persistent fault and answered from the corrected data, with no second scrub. Two wrong bits raise a sticky fatal flag, and the lookup is answered as a miss without any scrub. A saturating counter tracks the number of scrubs.

Top module: `tag_scrub_ctrl`

## Requirements
- R1: Stored word layout is ECC [39:33], tag [32:2], state [1:0]. A lookup accepted at one clock edge gives rspValid in the next cycle. If the entry is clean, rspHit is 1 exactly when the stored tag equals reqTag and state is non-zero, and rspState shows the stored state.
- R2: reqReady is high only while the controller is idle. It stays low from the cycle after acceptance until the cycle after the response, including the whole flush, scrub and reissue sequence.
- R3: A single-bit error in any of the 40 stored bits gives no response in that lookup cycle. flushPulse is high for exactly one cycle, the cycle after the lookup.
- R4: The scrub reads the entry and then writes the corrected tag and state with a recomputed code. A later lookup of that entry shows no error.
- R5: reissuePulse is high for one cycle, three cycles after flushPulse and after the write-back. The next cycle replays the lookup and always responds.
- R6: A double-bit error sets fatalErr, which stays set until reset. The lookup responds as a miss with rspState 0, and there is no flush.
- R7: If the replayed lookup finds a single-bit error again, persistErr is set (sticky). The response uses the corrected tag and state, and there is no further flush.
- R8: corrCount increments by one at each flush and saturates at 2^CNT_W-1.
- R9: When a fill and the scrub write target the same entry in the same cycle, the fill wins. The replayed lookup sees the filled word.
- R10: After reset reqReady is 1, all strobes and flags are 0, corrCount is 0, and every entry reads as a clean miss with state 0.
- R11: State 0 marks an invalid line, so a clean entry with state 0 misses even when its tag matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Lookup request valid |
| reqReady | output | 1 | Controller can accept a lookup |
| reqIdx | input | IDX_W | Entry index of the lookup |
| reqTag | input | 31 | Tag to compare |
| fillValid | input | 1 | Write an entry |
| fillIdx | input | IDX_W | Entry index to write |
| fillTag | input | 31 | Tag to store |
| fillState | input | 2 | State to store |
| fillFlip | input | 40 | Bits of the encoded word to invert on write |
| rspValid | output | 1 | Lookup result valid |
| rspHit | output | 1 | Lookup hit |
| rspState | output | 2 | State of the looked-up entry |
| flushPulse | output | 1 | Request flushed for scrub |
| reissuePulse | output | 1 | Request being replayed |
| corrCount | output | CNT_W | Saturating count of scrubs |
| fatalErr | output | 1 | Sticky uncorrectable error |
| persistErr | output | 1 | Sticky error seen again after scrub |

## Verification
The scrub write-back and a fill to the same entry can land in one cycle. The bench provokes this by timing a fill so that it meets the write cycle of a scrub that is already running. In one case the fill carries a clean new tag, and the replay must answer from that tag. In the other the fill carries a fresh single-bit error, and the replay must raise the persistent flag without a second flush. A reference model in the bench applies the scrub first and the fill second on the same edge, and every output is compared against it in every cycle.

// File: rtl/tag_scrub_pkg.sv
package tag_scrub_pkg;
  localparam int TAG_W     = 31;
  localparam int ST_W      = 2;
  localparam int DATA_W    = TAG_W + ST_W;
  localparam int HAM_W     = 6;
  localparam int ECC_W     = HAM_W + 1;
  localparam int WORD_W    = DATA_W + ECC_W;
  localparam int CODE_LAST = DATA_W + HAM_W;

  typedef enum logic [2:0] {
    S_IDLE, S_LOOKUP, S_FLUSH, S_SREAD, S_SWRITE, S_REISSUE
  } phaseT;

  typedef struct packed {
    logic capture;
    logic scrubLatch;
    logic scrubWrite;
  } ctlT;

  typedef struct packed {
    logic            single;
    logic            double;
    logic            hit;
    logic [ST_W-1:0] state;
  } statT;

  typedef struct packed {
    logic              single;
    logic              double;
    logic [DATA_W-1:0] data;
  } decT;

  function automatic logic [HAM_W-1:0] hamBits(input logic [DATA_W-1:0] d);
    logic [HAM_W-1:0] h;
    int k;
    h = '0;
    k = 0;
    for (int p = 1; p <= CODE_LAST; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (d[k]) h = h ^ HAM_W'(p);
        k++;
      end
    end
    return h;
  endfunction

  function automatic logic [WORD_W-1:0] eccEncode(input logic [DATA_W-1:0] d);
    logic [HAM_W-1:0] h;
    h = hamBits(d);
    return {(^d) ^ (^h), h, d};
  endfunction

  function automatic decT eccDecode(input logic [WORD_W-1:0] w);
    decT r;
    logic [HAM_W-1:0] syn;
    logic par;
    int k;
    syn = hamBits(w[DATA_W-1:0]) ^ w[DATA_W+HAM_W-1:DATA_W];
    par = ^w;
    r.data = w[DATA_W-1:0];
    k = 0;
    for (int p = 1; p <= CODE_LAST; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (par && syn == HAM_W'(p)) r.data[k] = ~r.data[k];
        k++;
      end
    end
    r.single = par && (syn <= HAM_W'(CODE_LAST));
    r.double = (!par && syn != '0) || (par && syn > HAM_W'(CODE_LAST));
    return r;
  endfunction
endpackage

// File: rtl/tag_scrub_dpath.sv
module tag_scrub_dpath
  import tag_scrub_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlT               ctl,
  input  logic [IDX_W-1:0]  reqIdx,
  input  logic [TAG_W-1:0]  reqTag,
  input  logic              fillValid,
  input  logic [IDX_W-1:0]  fillIdx,
  input  logic [TAG_W-1:0]  fillTag,
  input  logic [ST_W-1:0]   fillState,
  input  logic [WORD_W-1:0] fillFlip,
  output statT              stat
);
  logic [IDX_W-1:0]  reqIdxQ;
  logic [TAG_W-1:0]  reqTagQ;
  logic [DATA_W-1:0] fixQ;
  logic [WORD_W-1:0] memRd [DEPTH];
  logic [WORD_W-1:0] rdWord;
  logic [WORD_W-1:0] fillWord;
  logic [WORD_W-1:0] scrubWord;
  decT               dec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqIdxQ <= '0;
      reqTagQ <= '0;
      fixQ    <= '0;
    end else begin
      if (ctl.capture) begin
        reqIdxQ <= reqIdx;
        reqTagQ <= reqTag;
      end
      if (ctl.scrubLatch) fixQ <= dec.data;
    end
  end

  assign fillWord  = eccEncode({fillTag, fillState}) ^ fillFlip;
  assign scrubWord = eccEncode(fixQ);

  for (genvar g = 0; g < DEPTH; g++) begin : gEnt
    logic [WORD_W-1:0] entryQ;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        entryQ <= '0;
      end else if (fillValid && fillIdx == IDX_W'(g)) begin
        entryQ <= fillWord;
      end else if (ctl.scrubWrite && reqIdxQ == IDX_W'(g)) begin
        entryQ <= scrubWord;
      end
    end
    assign memRd[g] = entryQ;
  end

  assign rdWord = memRd[reqIdxQ];

  always_comb begin
    dec         = eccDecode(rdWord);
    stat.single = dec.single;
    stat.double = dec.double;
    stat.state  = dec.double ? '0 : dec.data[ST_W-1:0];
    stat.hit    = !dec.double && dec.data[DATA_W-1:ST_W] == reqTagQ
                  && dec.data[ST_W-1:0] != '0;
  end

  // R4
  scrub_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.scrubWrite && !(fillValid && fillIdx == reqIdxQ))
      |=> (!stat.single && !stat.double));
endmodule

// File: rtl/tag_scrub_ctl.sv
module tag_scrub_ctl
  import tag_scrub_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  statT             stat,
  output ctlT              ctl,
  output logic             reqReady,
  output logic             rspValid,
  output logic             flushPulse,
  output logic             reissuePulse,
  output logic [CNT_W-1:0] corrCount,
  output logic             fatalErr,
  output logic             persistErr
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  phaseT phaseQ;
  logic  replayQ;
  logic  goScrub;

  assign goScrub = phaseQ == S_LOOKUP && stat.single && !replayQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ     <= S_IDLE;
      replayQ    <= 1'b0;
      corrCount  <= '0;
      fatalErr   <= 1'b0;
      persistErr <= 1'b0;
    end else begin
      unique case (phaseQ)
        S_IDLE: if (reqValid) begin
          phaseQ  <= S_LOOKUP;
          replayQ <= 1'b0;
        end
        S_LOOKUP: begin
          if (goScrub) begin
            phaseQ <= S_FLUSH;
            if (corrCount != CNT_MAX) corrCount <= corrCount + 1'b1;
          end else begin
            phaseQ <= S_IDLE;
            if (stat.double) fatalErr <= 1'b1;
            if (stat.single) persistErr <= 1'b1;
          end
        end
        S_FLUSH:   phaseQ <= S_SREAD;
        S_SREAD:   phaseQ <= S_SWRITE;
        S_SWRITE:  phaseQ <= S_REISSUE;
        S_REISSUE: begin
          phaseQ  <= S_LOOKUP;
          replayQ <= 1'b1;
        end
        default:   phaseQ <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.capture    = phaseQ == S_IDLE && reqValid;
    ctl.scrubLatch = phaseQ == S_SREAD;
    ctl.scrubWrite = phaseQ == S_SWRITE;
  end

  assign reqReady     = phaseQ == S_IDLE;
  assign rspValid     = phaseQ == S_LOOKUP && !goScrub;
  assign flushPulse   = phaseQ == S_FLUSH;
  assign reissuePulse = phaseQ == S_REISSUE;

  // R2
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid || flushPulse || reissuePulse) |-> !reqReady);
  // R5
  reissue_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    reissuePulse |=> rspValid);
  // R6
  fatal_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    fatalErr |=> fatalErr);
  // R8
  corr_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (corrCount == CNT_MAX) |=> (corrCount == CNT_MAX));
  // R8
  corr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(corrCount) |-> (corrCount == CNT_W'($past(corrCount) + 1'b1)));
  // R3
  flush_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushPulse |=> !flushPulse);
endmodule

// File: rtl/tag_scrub_ctrl.sv
module tag_scrub_ctrl
  import tag_scrub_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = 4,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [IDX_W-1:0]  reqIdx,
  input  logic [TAG_W-1:0]  reqTag,
  input  logic              fillValid,
  input  logic [IDX_W-1:0]  fillIdx,
  input  logic [TAG_W-1:0]  fillTag,
  input  logic [ST_W-1:0]   fillState,
  input  logic [WORD_W-1:0] fillFlip,
  output logic              rspValid,
  output logic              rspHit,
  output logic [ST_W-1:0]   rspState,
  output logic              flushPulse,
  output logic              reissuePulse,
  output logic [CNT_W-1:0]  corrCount,
  output logic              fatalErr,
  output logic              persistErr
);
  ctlT  ctl;
  statT stat;

  tag_scrub_dpath #(.DEPTH(DEPTH)) dpath_i (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .reqIdx(reqIdx), .reqTag(reqTag),
    .fillValid(fillValid), .fillIdx(fillIdx), .fillTag(fillTag),
    .fillState(fillState), .fillFlip(fillFlip),
    .stat(stat)
  );

  tag_scrub_ctl #(.CNT_W(CNT_W)) ctl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .stat(stat), .ctl(ctl),
    .reqReady(reqReady), .rspValid(rspValid), .flushPulse(flushPulse),
    .reissuePulse(reissuePulse), .corrCount(corrCount),
    .fatalErr(fatalErr), .persistErr(persistErr)
  );

  assign rspHit   = stat.hit;
  assign rspState = stat.state;
endmodule

// File: tb/tag_scrub_ctrl_tb_top.sv
module tag_scrub_ctrl_tb_top;
  localparam int DEPTH = 16;
  localparam int CNT_W = 4;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, fillValid = 1'b0;
  logic [IDX_W-1:0] reqIdx = '0, fillIdx = '0;
  logic [30:0] reqTag = '0, fillTag = '0;
  logic [1:0]  fillState = '0;
  logic [39:0] fillFlip = '0;
  logic reqReady, rspValid, rspHit, flushPulse, reissuePulse, fatalErr, persistErr;
  logic [1:0] rspState;
  logic [CNT_W-1:0] corrCount;

  always #2 clk = ~clk;

  tag_scrub_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqIdx(reqIdx), .reqTag(reqTag), .fillValid(fillValid), .fillIdx(fillIdx),
    .fillTag(fillTag), .fillState(fillState), .fillFlip(fillFlip),
    .rspValid(rspValid), .rspHit(rspHit), .rspState(rspState),
    .flushPulse(flushPulse), .reissuePulse(reissuePulse), .corrCount(corrCount),
    .fatalErr(fatalErr), .persistErr(persistErr)
  );

  // Reference model: true contents plus an injected-error mask per entry
  logic [30:0] mTag [DEPTH];
  logic [1:0]  mSt  [DEPTH];
  logic [39:0] mFlip[DEPTH];
  int ph, mIdx, mCnt, cls;
  bit reiss, mFatal, mPers;
  logic [30:0] mReqTag, fixTag;
  logic [1:0]  fixSt;
  string curReq = "R10";
  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin mTag[i] = '0; mSt[i] = '0; mFlip[i] = '0; end
      ph = 0; mIdx = 0; mCnt = 0; reiss = 0; mFatal = 0; mPers = 0; mReqTag = '0;
    end else begin
      cls = $countones(mFlip[mIdx]);
      case (ph)
        0: if (reqValid) begin ph = 1; reiss = 0; mIdx = int'(reqIdx); mReqTag = reqTag; end
        1: if (cls == 1 && !reiss) begin ph = 2; if (mCnt < CMAX) mCnt++; end
           else begin ph = 0; if (cls >= 2) mFatal = 1; if (cls == 1) mPers = 1; end
        2: ph = 3;
        3: begin fixTag = mTag[mIdx]; fixSt = mSt[mIdx]; ph = 4; end
        4: begin mTag[mIdx] = fixTag; mSt[mIdx] = fixSt; mFlip[mIdx] = '0; ph = 5; end
        default: begin ph = 1; reiss = 1; end
      endcase
      if (fillValid) begin
        mTag[fillIdx] = fillTag; mSt[fillIdx] = fillState; mFlip[fillIdx] = fillFlip;
      end
    end
  end

  task automatic chk(string rq, string nm, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s (%s) %s: got %0h expected %0h", rq, curReq, nm, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      int c;
      bit eRsp;
      c = $countones(mFlip[mIdx]);
      eRsp = (ph == 1) && !(c == 1 && !reiss);
      chk("R2", "reqReady", int'(reqReady), int'(ph == 0));
      chk("R3", "rspValid", int'(rspValid), int'(eRsp));
      if (eRsp) begin
        chk("R1", "rspHit", int'(rspHit),
            int'(c < 2 && mTag[mIdx] == mReqTag && mSt[mIdx] != 0));
        chk("R1", "rspState", int'(rspState), c >= 2 ? 0 : int'(mSt[mIdx]));
      end
      chk("R3", "flushPulse", int'(flushPulse), int'(ph == 2));
      chk("R5", "reissuePulse", int'(reissuePulse), int'(ph == 5));
      chk("R8", "corrCount", int'(corrCount), mCnt);
      chk("R6", "fatalErr", int'(fatalErr), int'(mFatal));
      chk("R7", "persistErr", int'(persistErr), int'(mPers));
    end
  end

  task automatic finishRun();
    done = 1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog (%s): got %0d cycles expected completion", curReq, cyc);
      finishRun();
    end
  end

  task automatic fill(int idx, logic [30:0] t, logic [1:0] s, logic [39:0] f);
    @(negedge clk);
    fillValid = 1; fillIdx = IDX_W'(idx); fillTag = t; fillState = s; fillFlip = f;
    @(negedge clk);
    fillValid = 0; fillFlip = '0;
  endtask

  task automatic look(int idx, logic [30:0] t);
    @(negedge clk);
    reqValid = 1; reqIdx = IDX_W'(idx); reqTag = t;
    @(negedge clk);
    reqValid = 0;
    repeat (8) @(negedge clk);
  endtask

  // Lookup with a fill landing on the scrub write-back edge
  task automatic lookCollide(int idx, logic [30:0] t, logic [30:0] ft, logic [39:0] ff);
    @(negedge clk);
    reqValid = 1; reqIdx = IDX_W'(idx); reqTag = t;
    @(negedge clk);
    reqValid = 0;
    repeat (3) @(negedge clk);
    fillValid = 1; fillIdx = IDX_W'(idx); fillTag = ft; fillState = 2'd3; fillFlip = ff;
    @(negedge clk);
    fillValid = 0; fillFlip = '0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    int pos[8] = '{0, 1, 5, 20, 32, 33, 36, 39};
    repeat (3) @(negedge clk);
    rstN = 1;
    curReq = "R10"; repeat (2) @(negedge clk);
    look(5, 31'h0);
    curReq = "R1";
    fill(1, 31'h1234567, 2'd2, '0);
    look(1, 31'h1234567);
    look(1, 31'h1234566);
    curReq = "R11";
    fill(2, 31'h0ABCDEF, 2'd0, '0);
    look(2, 31'h0ABCDEF);
    curReq = "R3";
    foreach (pos[i]) begin
      fill(3, 31'h3C3C3C3 + 31'(i), 2'd1, 40'd1 << pos[i]);
      look(3, 31'h3C3C3C3 + 31'(i));
      curReq = "R4";
      look(3, 31'h3C3C3C3 + 31'(i));
      curReq = "R5";
    end
    curReq = "R6";
    fill(4, 31'h7000001, 2'd3, (40'd1 << 3) | (40'd1 << 17));
    look(4, 31'h7000001);
    fill(4, 31'h7000002, 2'd3, (40'd1 << 39) | (40'd1 << 8));
    look(4, 31'h7000002);
    curReq = "R9";
    fill(6, 31'h0006666, 2'd1, 40'd1 << 12);
    lookCollide(6, 31'h5550000, 31'h5550000, '0);
    curReq = "R7";
    fill(7, 31'h0007777, 2'd1, 40'd1 << 25);
    lookCollide(7, 31'h0007777, 31'h0007777, 40'd1 << 30);
    curReq = "R8";
    for (int n = 0; n < CMAX + 3; n++) begin
      fill(8, 31'(n + 100), 2'd2, 40'd1 << (n % 40));
      look(8, 31'(n + 100));
    end
    repeat (4) @(negedge clk);
    finishRun();
  end
endmodule